// File: doc/BRIEF.md
# Reference Supervisor and Holdover Controller

This block is the supervisory part of a digital PLL that produces a synchronous Ethernet clock. It watches several candidate reference clocks and chooses which one drives the loop. It also decides the loop's operating mode. The loop filter and the oscillator are outside the block. Each reference arrives as a one-cycle pulse per edge, already resampled into the master-clock domain.

Every reference has its own monitor. A reference fails when its edges stop for longer than a programmable timeout. It also fails when the number of edges it gives in a fixed master-clock window falls outside a programmable expected count plus or minus a margin. Software derives that margin from the ppm tolerance it wants. A failed reference becomes usable again only after a programmable run of consecutive good windows.

The selector has three modes:
- **Free-run:** no reference has yet qualified. The nominal frequency word is issued.
- **Locked:** the selector forwards the loop's control word. It also keeps a first-order running average of that word.
- **Holdover:** the active reference has failed and no other reference is valid. The frozen average is issued.

A change of reference takes a phase offset from the last edge timestamps of the new and old references. The loop uses this offset to absorb the step.

Top module: `ref_supervisor`

## Requirements
- R1: After reset, mode_o is free-run (0), sel_o is 0, irq_o is 0, phase_off_o is 0 and freq_o equals nom_cw_i.
- R2: While no reference has ever qualified, mode_o stays at free-run (0) and freq_o follows nom_cw_i.
- R3: A reference is valid once it has given qual_i consecutive windows whose edge count lies within exp_cnt_i ± tol_i. A window is win_len_i master cycles long. On the first qualification, the block enters locked mode (1), selects the lowest-index valid reference and sets phase_off_o to 0.
- R4: A reference with no edge for timeout_i master cycles is failed at once.
- R5: A reference whose window edge count differs from exp_cnt_i by more than tol_i is failed at the end of that window.
- R6: When the active reference fails in locked mode, irq_o is high for exactly one cycle, on the cycle after the failure.
- R7: On that failure, if any other reference is valid, the block stays locked and selects the lowest-index valid reference.
- R8: On that failure, if no reference is valid, the block enters holdover (mode 2).
- R9: While the active reference stays valid, sel_o does not change, even if a lower-index reference becomes valid (non-revertive).
- R10: In locked mode, freq_o equals cw_i.
- R11: The average is updated in locked mode by avg += (cw − avg) >> avg_shift_i, with 8 fraction bits. Updates stop on the cycle the active reference fails. After a long constant cw_i, the holdover freq_o is within one LSB of cw_i, and it does not follow later changes of cw_i.
- R12: On a change of selected reference out of locked or holdover mode, phase_off_o becomes (stamp of new reference − stamp of previous reference) mod 2^16. The stamp of a reference is the master-cycle time of its last edge.
- R13: Edge-period jitter whose window count stays within tolerance does not fail a reference or raise irq_o.
- R14: In holdover, requalification of a reference returns the block to locked mode. The block never returns to free-run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_pulse_i | input | N_REF | One-cycle pulse per reference edge, master domain |
| cw_i | input | CW_W | Loop frequency control word |
| nom_cw_i | input | CW_W | Nominal (free-run) frequency word |
| win_len_i | input | WIN_W | Monitor window length in master cycles |
| exp_cnt_i | input | CNT_W | Expected edges per window |
| tol_i | input | CNT_W | Allowed deviation from the expected count |
| timeout_i | input | TMO_W | Edge-free cycles that declare loss of activity |
| qual_i | input | QUAL_W | Consecutive good windows needed to requalify |
| avg_shift_i | input | K_W | IIR shift k of the holdover average |
| sel_o | output | SEL_W | Index of the active reference |
| mode_o | output | 2 | 0 free-run, 1 locked, 2 holdover |
| freq_o | output | CW_W | Frequency word for the oscillator |
| phase_off_o | output | PH_W | Phase offset captured at a reference change |
| irq_o | output | 1 | One-cycle alarm on failure of the active reference |

## Verification
The assertions assume that reset is applied before the first clock edge and that the configuration inputs stay static while out of reset. They also assume that timeout_i exceeds the nominal edge spacing, so that a healthy reference never trips the activity check. The stimulus meets these assumptions in three ways. All configuration is set during reset. Reference pulse trains have periods well inside the timeout. The only inputs changed at run time are the reference pulses and cw_i, and both are driven on the falling clock edge.

// File: rtl/ref_supervisor_pkg.sv
package ref_supervisor_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_LOCK = 2'd1,
    MODE_HOLD = 2'd2
  } mode_e;
endpackage

// File: rtl/ref_mon.sv
module ref_mon #(
  parameter int CNT_W  = 12,
  parameter int TMO_W  = 16,
  parameter int QUAL_W = 4,
  parameter int PH_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              win_end_i,
  input  logic [CNT_W-1:0]  exp_i,
  input  logic [CNT_W-1:0]  tol_i,
  input  logic [TMO_W-1:0]  timeout_i,
  input  logic [QUAL_W-1:0] qual_i,
  input  logic [PH_W-1:0]   ts_i,
  output logic              valid_o,
  output logic [PH_W-1:0]   stamp_o
);
  logic [CNT_W-1:0]  edge_cnt;
  logic [CNT_W:0]    tot, diff;
  logic [TMO_W-1:0]  idle;
  logic [QUAL_W-1:0] run;
  logic [QUAL_W:0]   run_nxt;
  logic              win_ok, dead;

  always_comb begin
    tot     = {1'b0, edge_cnt} + {{CNT_W{1'b0}}, pulse_i};
    diff    = (tot > {1'b0, exp_i}) ? tot - {1'b0, exp_i} : {1'b0, exp_i} - tot;
    win_ok  = diff <= {1'b0, tol_i};
    dead    = idle >= timeout_i;
    run_nxt = {1'b0, run} + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cnt <= '0;
      idle     <= '0;
      run      <= '0;
      valid_o  <= 1'b0;
      stamp_o  <= '0;
    end else begin
      edge_cnt <= win_end_i ? '0 : tot[CNT_W-1:0];
      if (pulse_i) begin
        idle    <= '0;
        stamp_o <= ts_i;
      end else if (idle != {TMO_W{1'b1}}) begin
        idle <= idle + 1'b1;
      end
      if (dead) begin
        valid_o <= 1'b0;
        run     <= '0;
      end else if (win_end_i) begin
        if (!win_ok) begin
          valid_o <= 1'b0;
          run     <= '0;
        end else begin
          if (run != {QUAL_W{1'b1}}) run <= run_nxt[QUAL_W-1:0];
          if (run_nxt >= {1'b0, qual_i}) valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ref_sel.sv
module ref_sel
  import ref_supervisor_pkg::*;
#(
  parameter int N_REF = 3,
  parameter int PH_W  = 16,
  localparam int SEL_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_REF-1:0]           valid_i,
  input  logic [N_REF-1:0][PH_W-1:0] stamp_i,
  output mode_e                      mode_o,
  output logic [SEL_W-1:0]           sel_o,
  output logic                       irq_o,
  output logic [PH_W-1:0]            phase_o,
  output logic                       upd_o
);
  logic [SEL_W-1:0] pick;
  logic             any;

  always_comb begin
    any  = |valid_i;
    pick = '0;
    for (int i = N_REF - 1; i >= 0; i--) begin
      if (valid_i[i]) pick = i[SEL_W-1:0];
    end
    upd_o = (mode_o == MODE_LOCK) && valid_i[sel_o];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= MODE_FREE;
      sel_o   <= '0;
      irq_o   <= 1'b0;
      phase_o <= '0;
    end else begin
      irq_o <= 1'b0;
      unique case (mode_o)
        MODE_FREE: if (any) begin
          mode_o  <= MODE_LOCK;
          sel_o   <= pick;
          phase_o <= '0;
        end
        MODE_LOCK: if (!valid_i[sel_o]) begin
          irq_o <= 1'b1;
          if (any) begin
            sel_o   <= pick;
            phase_o <= stamp_i[pick] - stamp_i[sel_o];
          end else begin
            mode_o <= MODE_HOLD;
          end
        end
        MODE_HOLD: if (any) begin
          mode_o  <= MODE_LOCK;
          sel_o   <= pick;
          phase_o <= stamp_i[pick] - stamp_i[sel_o];
        end
        default: mode_o <= MODE_FREE;
      endcase
    end
  end
endmodule

// File: rtl/hold_avg.sv
module hold_avg #(
  parameter int CW_W   = 24,
  parameter int FRAC_W = 8,
  parameter int K_W    = 3,
  localparam int AW    = CW_W + FRAC_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            seed_i,
  input  logic            upd_i,
  input  logic [CW_W-1:0] nom_i,
  input  logic [CW_W-1:0] cw_i,
  input  logic [K_W-1:0]  k_i,
  output logic [CW_W-1:0] avg_o
);
  logic signed [AW-1:0] acc, target, seed, delta;

  always_comb begin
    target = $signed({1'b0, cw_i, {FRAC_W{1'b0}}});
    seed   = $signed({1'b0, nom_i, {FRAC_W{1'b0}}});
    delta  = (target - acc) >>> k_i;
    avg_o  = acc[CW_W+FRAC_W-1:FRAC_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc <= '0;
    else if (seed_i) acc <= seed;
    else if (upd_i)  acc <= acc + delta;
  end
endmodule

// File: rtl/ref_supervisor.sv
module ref_supervisor
  import ref_supervisor_pkg::*;
#(
  parameter int N_REF  = 3,
  parameter int CNT_W  = 12,
  parameter int WIN_W  = 16,
  parameter int TMO_W  = 16,
  parameter int QUAL_W = 4,
  parameter int CW_W   = 24,
  parameter int FRAC_W = 8,
  parameter int K_W    = 3,
  parameter int PH_W   = 16,
  localparam int SEL_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REF-1:0]  ref_pulse_i,
  input  logic [CW_W-1:0]   cw_i,
  input  logic [CW_W-1:0]   nom_cw_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic [CNT_W-1:0]  exp_cnt_i,
  input  logic [CNT_W-1:0]  tol_i,
  input  logic [TMO_W-1:0]  timeout_i,
  input  logic [QUAL_W-1:0] qual_i,
  input  logic [K_W-1:0]    avg_shift_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [1:0]        mode_o,
  output logic [CW_W-1:0]   freq_o,
  output logic [PH_W-1:0]   phase_off_o,
  output logic              irq_o
);
  logic [WIN_W-1:0]            win_cnt;
  logic                        win_end;
  logic [PH_W-1:0]             ts;
  logic [N_REF-1:0]            ref_valid;
  logic [N_REF-1:0][PH_W-1:0]  stamps;
  mode_e                       mode;
  logic                        upd;
  logic [CW_W-1:0]             avg;

  assign win_end = win_cnt >= (win_len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt <= '0;
      ts      <= '0;
    end else begin
      win_cnt <= win_end ? '0 : win_cnt + 1'b1;
      ts      <= ts + 1'b1;
    end
  end

  for (genvar g = 0; g < N_REF; g++) begin : g_mon
    ref_mon #(.CNT_W(CNT_W), .TMO_W(TMO_W), .QUAL_W(QUAL_W), .PH_W(PH_W)) u_mon (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pulse_i   (ref_pulse_i[g]),
      .win_end_i (win_end),
      .exp_i     (exp_cnt_i),
      .tol_i     (tol_i),
      .timeout_i (timeout_i),
      .qual_i    (qual_i),
      .ts_i      (ts),
      .valid_o   (ref_valid[g]),
      .stamp_o   (stamps[g])
    );
  end

  ref_sel #(.N_REF(N_REF), .PH_W(PH_W)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (ref_valid),
    .stamp_i (stamps),
    .mode_o  (mode),
    .sel_o   (sel_o),
    .irq_o   (irq_o),
    .phase_o (phase_off_o),
    .upd_o   (upd)
  );

  hold_avg #(.CW_W(CW_W), .FRAC_W(FRAC_W), .K_W(K_W)) u_avg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (mode == MODE_FREE),
    .upd_i  (upd),
    .nom_i  (nom_cw_i),
    .cw_i   (cw_i),
    .k_i    (avg_shift_i),
    .avg_o  (avg)
  );

  always_comb begin
    mode_o = mode;
    unique case (mode)
      MODE_LOCK: freq_o = cw_i;
      MODE_HOLD: freq_o = avg;
      default:   freq_o = nom_cw_i;
    endcase
  end
endmodule

// File: rtl/ref_supervisor_chk.sv
module ref_supervisor_chk #(
  parameter int N_REF = 3,
  parameter int CW_W  = 24,
  localparam int SEL_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_o,
  input logic [SEL_W-1:0] sel_o,
  input logic             irq_o,
  input logic [CW_W-1:0]  freq_o,
  input logic [N_REF-1:0] valid_i
);
  p_mode_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);

  p_irq_on_fail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && !valid_i[sel_o]) |=> irq_o);

  p_irq_only_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mode_o == 2'd1));

  p_nonrevert_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && valid_i[sel_o]) |=> ($stable(sel_o) && mode_o == 2'd1));

  p_hold_freeze_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && $past(mode_o) == 2'd2) |-> $stable(freq_o));

  p_no_free_return_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) != 2'd0) |-> (mode_o != 2'd0));
endmodule

bind ref_supervisor ref_supervisor_chk #(.N_REF(N_REF), .CW_W(CW_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_o  (mode_o),
  .sel_o   (sel_o),
  .irq_o   (irq_o),
  .freq_o  (freq_o),
  .valid_i (ref_valid)
);

// File: tb/ref_supervisor_bench.sv
module ref_supervisor_bench;
  localparam int N = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      pulse = '0;
  logic [23:0]       cw = 24'd1000;
  logic [1:0]        sel;
  logic [1:0]        mode;
  logic [23:0]       freq;
  logic [15:0]       phoff;
  logic              irq;

  int tests = 0, fails = 0;
  int irq_cnt = 0;
  longint cyc = 0;
  bit done = 0;

  bit     en   [N];
  int     per  [N];
  bit     jit  [N];
  int     cntd [N];
  bit     jtog [N];
  longint t_last [N];
  longint t_prev [N];
  logic [1:0] sel_prev = '0;
  logic [1:0] mode_prev = '0;

  always #4 clk = ~clk;

  ref_supervisor u_ref_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .ref_pulse_i(pulse), .cw_i(cw),
    .nom_cw_i(24'd1000), .win_len_i(16'd64), .exp_cnt_i(12'd8), .tol_i(12'd1),
    .timeout_i(16'd20), .qual_i(4'd2), .avg_shift_i(3'd3),
    .sel_o(sel), .mode_o(mode), .freq_o(freq), .phase_off_o(phoff), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint t_used(input int r, input longint s);
    return (t_last[r] < s) ? t_last[r] : t_prev[r];
  endfunction

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      // R12: phase offset at each reference change out of lock or holdover
      if (sel != sel_prev && mode == 2'd1 && mode_prev != 2'd0) begin
        logic [15:0] e;
        e = 16'(t_used(int'(sel), cyc) - t_used(int'(sel_prev), cyc));
        chk(phoff == e, "R12 phase offset", phoff, e);
      end
      sel_prev  = sel;
      mode_prev = mode;
    end
    for (int r = 0; r < N; r++) begin
      pulse[r] = 1'b0;
      if (en[r]) begin
        if (cntd[r] == 0) begin
          pulse[r]  = 1'b1;
          t_prev[r] = t_last[r];
          t_last[r] = cyc + 1;
          jtog[r]   = ~jtog[r];
          cntd[r]   = per[r] - 1 + (jit[r] ? (jtog[r] ? 1 : -1) : 0);
        end else begin
          cntd[r]--;
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    int base;
    for (int r = 0; r < N; r++) begin
      en[r] = 0; per[r] = 8; jit[r] = 0; cntd[r] = r * 3; jtog[r] = 0;
      t_last[r] = 0; t_prev[r] = 0;
    end
    wait_cyc(3);
    chk(mode == 2'd0, "R1 mode", mode, 0);
    chk(sel == 2'd0, "R1 sel", sel, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(phoff == 16'd0, "R1 phase", phoff, 0);
    chk(freq == 24'd1000, "R1 freq", freq, 1000);
    rst_n = 1'b1;
    wait_cyc(200);
    chk(mode == 2'd0, "R2 free-run mode", mode, 0);
    chk(freq == 24'd1000, "R2 free-run freq", freq, 1000);

    // R3: refs 1 and 2 qualify, lowest valid chosen
    en[1] = 1; en[2] = 1;
    wait_cyc(320);
    chk(mode == 2'd1, "R3 lock mode", mode, 1);
    chk(sel == 2'd1, "R3 lowest valid", sel, 1);
    chk(phoff == 16'd0, "R3 phase from free-run", phoff, 0);

    // R9: ref0 qualifies, no revert
    en[0] = 1;
    wait_cyc(320);
    chk(sel == 2'd1, "R9 non-revertive", sel, 1);

    // R10: lock forwards control word
    cw = 24'd1200;
    wait_cyc(2);
    chk(freq == 24'd1200, "R10 lock freq", freq, 1200);
    wait_cyc(300);

    // R4, R6, R7: ref1 loses activity
    base = irq_cnt;
    en[1] = 0;
    wait_cyc(60);
    chk(irq_cnt - base == 1, "R6 one irq on loss", irq_cnt - base, 1);
    chk(sel == 2'd0, "R4 R7 switch to ref0", sel, 0);
    chk(mode == 2'd1, "R7 stay locked", mode, 1);

    // R5: ref0 drifts (period 6 -> ~10 per window)
    base = irq_cnt;
    per[0] = 6;
    wait_cyc(140);
    chk(irq_cnt - base == 1, "R5 R6 irq on drift", irq_cnt - base, 1);
    chk(sel == 2'd2, "R5 R7 switch to ref2", sel, 2);

    // R13: jitter on ref2 stays within tolerance
    base = irq_cnt;
    jit[2] = 1;
    wait_cyc(640);
    chk(irq_cnt == base, "R13 no irq under jitter", irq_cnt - base, 0);
    chk(sel == 2'd2 && mode == 2'd1, "R13 ref2 kept", sel, 2);

    // R8, R11: all gone -> holdover on average
    base = irq_cnt;
    en[2] = 0;
    wait_cyc(60);
    chk(irq_cnt - base == 1, "R6 irq before holdover", irq_cnt - base, 1);
    chk(mode == 2'd2, "R8 holdover", mode, 2);
    chk(freq == 24'd1200 || freq == 24'd1199, "R11 holdover average", freq, 1200);
    base = int'(freq);
    cw = 24'd5000;
    wait_cyc(200);
    chk(freq == 24'(base), "R11 frozen average", freq, base);

    // R14: ref1 returns, requalifies after qual good windows
    en[1] = 1; cntd[1] = 5;
    wait_cyc(96);
    chk(mode == 2'd2, "R3 not yet requalified", mode, 2);
    wait_cyc(200);
    chk(mode == 2'd1, "R14 relock", mode, 1);
    chk(sel == 2'd1, "R14 ref1 selected", sel, 1);
    chk(freq == 24'd5000, "R10 relock freq", freq, 5000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule